// File: doc/BRIEF.md
# Slow-Window Transfer Acknowledge and Bus-Error Watchdog

This block closes bus cycles for a 68000-family processor. For almost every address it answers a cycle at once: as soon as both the address strobe and the data strobe are low, the transfer acknowledge is pulled low in the same clock cycle. One small address window is treated differently. It holds a slow peripheral, so the block holds back the acknowledge there and passes on the peripheral's own acknowledge instead.

A cycle into the window can hang if the peripheral never answers. To prevent this, a watchdog counts rising edges of a separate slow reference clock while the cycle is waiting. The slow clock is sampled through a two-flop synchronizer in the CPU clock domain. When the count reaches the limit, the block pulls the bus-error line low, so the CPU takes an exception and does not hang. The watchdog clears once the address strobe returns high.

The acknowledge is an open-drain line. The block gives it as a drive enable together with a drive value that is always zero. The board provides the pull-up.

Top module: `xfer_ack_ctrl`

## Requirements
- R1: A cycle is live when `as_ni` and `ds_ni` are both low. While a cycle is live and the address lies outside the window, `ack_oe_o` is 1 in that same clock cycle.
- R2: While `as_ni` or `ds_ni` is high, `ack_oe_o` is 0.
- R3: The window covers byte addresses 0x90000 through 0x93FFF inclusive. The addresses 0x8FFFF and 0x94000 are outside it.
- R4: During a live cycle inside the window, `ack_oe_o` follows the peripheral acknowledge. It is 1 exactly while `dev_ack_ni` is low.
- R5: A live window cycle with no peripheral acknowledge drives `berr_no` low once 8 rising edges of `slow_clk_i` have occurred since the cycle began. `berr_no` is observed a few fast cycles after the 8th edge.
- R6: After only 7 such edges, `berr_no` is still high.
- R7: A peripheral acknowledge that arrives before the 8th edge, or in the same fast cycle as the synchronized 8th edge, ends the wait. `berr_no` then stays high for as long as the strobe is held.
- R8: When `as_ni` goes high, `berr_no` returns high within two fast cycles and the edge count is cleared. The next window cycle therefore needs a full 8 edges again.
- R9: `ack_val_o` is always 0. The acknowledge is only ever pulled low or left floating.
- R10: While `rst_ni` is low, `ack_oe_o` is 0 and `berr_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast CPU clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slow_clk_i | input | 1 | Slow reference clock, sampled as asynchronous data |
| addr_i | input | 20 | CPU byte address |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 1 | Data strobe, active low |
| dev_ack_ni | input | 1 | Acknowledge from the windowed peripheral, active low |
| ack_oe_o | output | 1 | Drive enable of the open-drain acknowledge (1 = pull low) |
| ack_val_o | output | 1 | Drive value of the acknowledge, constant 0 |
| berr_no | output | 1 | Bus error, active low |

## Verification
The peripheral acknowledge and the eighth synchronized slow-clock edge can land in the same fast clock cycle. In that cycle one path wants to close the cycle normally and the other wants to raise a bus error. The bench provokes this case by waiting for the eighth slow edge and then driving `dev_ack_ni` low exactly two fast cycles later, which places it in the cycle where the synchronized tick is seen. It then judges that the acknowledge is driven and that `berr_no` stays high through several more slow edges. The single-path outcomes are covered as well: an acknowledge at the fifth edge, and a timeout with no acknowledge at all.

// File: rtl/xfer_ack_pkg.sv
package xfer_ack_pkg;

    // Progress of one window cycle through the watchdog.
    typedef enum logic [1:0] {
        WT_IDLE  = 2'd0,  // no window cycle in progress
        WT_WAIT  = 2'd1,  // waiting for the peripheral, counting slow ticks
        WT_ACKED = 2'd2,  // peripheral answered, counting frozen
        WT_FAULT = 2'd3   // limit reached, bus error raised
    } wait_state_t;

    // Three-stage sampler of the slow reference clock.
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } tick_sync_t;

endpackage

// File: rtl/slow_tick_detect.sv
module slow_tick_detect
    import xfer_ack_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slow_clk_i,
    output logic tick_o
);

    tick_sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = slow_clk_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    // One-cycle pulse on each rising edge of the synchronized slow clock.
    assign tick_o = sync_q.stable & ~sync_q.prev;

    // R5: a tick is a single-cycle pulse, so each slow edge is counted once.
    p_tick_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/window_match.sv
module window_match #(
    parameter int unsigned          ADDR_W    = 20,
    parameter logic [ADDR_W-1:0]    WIN_BASE  = 20'h90000,
    parameter int unsigned          WIN_BYTES = 32'h4000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(WIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] HI_MASK  = ~OFS_MASK;

    // The window size is a power of two and the base is aligned to it, so a
    // match of the upper bits alone selects the whole range.
    assign hit_o = ((addr_i ^ WIN_BASE) & HI_MASK) == '0;

    initial begin
        p_win_aligned_r3: assert ((WIN_BASE & OFS_MASK) == '0)
            else $error("window base not aligned to its size");
    end

endmodule

// File: rtl/wait_watchdog.sv
module wait_watchdog
    import xfer_ack_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic as_ni,
    input  logic win_cycle_i,
    input  logic dev_ack_i,
    input  logic tick_i,
    output logic berr_o
);

    localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        wait_state_t   st;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (as_ni) begin
            // End of the bus cycle: clear the wait flag and the count.
            wd_d.st  = WT_IDLE;
            wd_d.cnt = '0;
        end else begin
            unique case (wd_q.st)
                WT_IDLE: begin
                    if (win_cycle_i) wd_d.st = dev_ack_i ? WT_ACKED : WT_WAIT;
                end
                WT_WAIT: begin
                    // The peripheral wins over a tick that lands in the same cycle.
                    if (dev_ack_i) begin
                        wd_d.st = WT_ACKED;
                    end else if (tick_i) begin
                        wd_d.cnt = wd_q.cnt + 1'b1;
                        if (wd_q.cnt == LAST_CNT) wd_d.st = WT_FAULT;
                    end
                end
                WT_ACKED: wd_d = wd_q;
                WT_FAULT: wd_d = wd_q;
                default:  wd_d.st = WT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wd_q.st  <= WT_IDLE;
            wd_q.cnt <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign berr_o = (wd_q.st == WT_FAULT);

    // R8: the strobe going high clears the fault on the next edge.
    p_berr_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        as_ni |=> !berr_o);

    // R6: the count never passes the limit.
    p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_q.cnt <= CW'(TIMEOUT_TICKS));

    // R7: once the peripheral has answered in a window cycle, no error follows.
    p_ack_blocks_berr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!as_ni && !berr_o && win_cycle_i && dev_ack_i) |=> !berr_o);

endmodule

// File: rtl/xfer_ack_ctrl.sv
module xfer_ack_ctrl #(
    parameter int unsigned       ADDR_W        = 20,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 20'h90000,
    parameter int unsigned       WIN_BYTES     = 32'h4000,
    parameter int unsigned       TIMEOUT_TICKS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              slow_clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_ni,
    input  logic              ds_ni,
    input  logic              dev_ack_ni,
    output logic              ack_oe_o,
    output logic              ack_val_o,
    output logic              berr_no
);

    logic tick;
    logic in_win;
    logic cyc_live;
    logic win_cycle;
    logic dev_ack;
    logic berr;

    slow_tick_detect u_tick (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .slow_clk_i (slow_clk_i),
        .tick_o     (tick)
    );

    window_match #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_win (
        .addr_i (addr_i),
        .hit_o  (in_win)
    );

    assign cyc_live  = ~as_ni & ~ds_ni & rst_ni;
    assign win_cycle = cyc_live & in_win;
    assign dev_ack   = ~dev_ack_ni;

    wait_watchdog #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_wd (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .as_ni       (as_ni),
        .win_cycle_i (win_cycle),
        .dev_ack_i   (dev_ack),
        .tick_i      (tick),
        .berr_o      (berr)
    );

    assign ack_oe_o  = cyc_live & (~in_win | dev_ack);
    assign ack_val_o = 1'b0;
    assign berr_no   = ~berr;

    // R2: no acknowledge outside a live cycle.
    p_idle_no_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (as_ni || ds_ni) |-> !ack_oe_o);

    // R5: a bus error only starts right after a slow tick was seen.
    p_berr_from_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(berr_no) |-> $past(tick));

    // R1: a live cycle outside the window is acknowledged without delay.
    p_outside_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!as_ni && !ds_ni && !in_win) |-> ack_oe_o);

endmodule

// File: tb/xfer_ack_ctrl_test.sv
`timescale 1ns/1ps
module xfer_ack_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic [19:0] addr = 20'h00000;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        dev_ack_n = 1'b1;
    logic        ack_oe;
    logic        ack_val;
    logic        berr_n;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned div_cnt  = 0;
    bit          done     = 1'b0;

    typedef struct {
        string req;
        logic  ack;
        logic  berr_n;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    // Slow reference clock at one hundredth of the fast clock.
    always @(posedge clk) begin
        if (div_cnt == 49) begin
            div_cnt  <= 0;
            slow_clk <= ~slow_clk;
        end else begin
            div_cnt <= div_cnt + 1;
        end
    end

    xfer_ack_ctrl uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .slow_clk_i (slow_clk),
        .addr_i     (addr),
        .as_ni      (as_n),
        .ds_ni      (ds_n),
        .dev_ack_ni (dev_ack_n),
        .ack_oe_o   (ack_oe),
        .ack_val_o  (ack_val),
        .berr_no    (berr_n)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (ack_oe !== e.ack || berr_n !== e.berr_n || ack_val !== 1'b0) begin
                n_fail++;
                $display("FAIL %s: ack_oe=%b berr_n=%b ack_val=%b expected ack_oe=%b berr_n=%b ack_val=0",
                         e.req, ack_oe, berr_n, ack_val, e.ack, e.berr_n);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic a, input logic b);
        exp_q.push_back('{req, a, b});
        step(1);
    endtask

    // Wait for n slow rising edges, then let the synchronizer settle.
    task automatic slow_rises(input int n);
        repeat (n) @(posedge slow_clk);
        step(6);
    endtask

    task automatic start_cycle(input logic [19:0] a);
        addr = a;
        as_n = 1'b0;
        ds_n = 1'b0;
    endtask

    task automatic end_cycle();
        as_n = 1'b1;
        ds_n = 1'b1;
        dev_ack_n = 1'b1;
        step(3);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        int unsigned wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        step(2);
        expect_out("R10 reset", 1'b0, 1'b1);
        start_cycle(20'h12345);
        expect_out("R10 reset holds outputs during live strobes", 1'b0, 1'b1);
        as_n = 1'b1; ds_n = 1'b1;
        rst_n = 1'b1;
        step(3);

        // R2: idle and half-started cycles
        addr = 20'h12345;
        expect_out("R2 strobes high", 1'b0, 1'b1);
        as_n = 1'b0;
        expect_out("R2 data strobe still high", 1'b0, 1'b1);

        // R1: immediate acknowledge outside the window
        ds_n = 1'b0;
        #0.5;
        exp_q.push_back('{"R1 outside window acked at once", 1'b1, 1'b1});
        step(1);
        end_cycle();

        // R3: boundaries
        start_cycle(20'h8FFFF);
        expect_out("R3 0x8FFFF is outside", 1'b1, 1'b1);
        end_cycle();
        start_cycle(20'h94000);
        expect_out("R3 0x94000 is outside", 1'b1, 1'b1);
        end_cycle();
        start_cycle(20'h90000);
        expect_out("R3 0x90000 waits", 1'b0, 1'b1);
        end_cycle();
        start_cycle(20'h93FFF);
        expect_out("R3 0x93FFF waits", 1'b0, 1'b1);
        end_cycle();

        // R4/R7: peripheral answers at the fifth edge
        slow_rises(1);
        start_cycle(20'h91000);
        slow_rises(5);
        expect_out("R4 no ack before peripheral", 1'b0, 1'b1);
        dev_ack_n = 1'b0;
        expect_out("R4 ack follows peripheral", 1'b1, 1'b1);
        slow_rises(6);
        expect_out("R7 acked cycle never errors", 1'b1, 1'b1);
        end_cycle();

        // R5/R6: timeout with no answer
        slow_rises(1);
        start_cycle(20'h92000);
        slow_rises(7);
        expect_out("R6 no error after 7 edges", 1'b0, 1'b1);
        slow_rises(1);
        expect_out("R5 error after 8 edges", 1'b0, 1'b0);
        as_n = 1'b1; ds_n = 1'b1;
        step(2);
        expect_out("R8 error released with strobe", 1'b0, 1'b1);
        step(2);

        // R8: fresh count for the next window cycle
        slow_rises(1);
        start_cycle(20'h90010);
        slow_rises(7);
        expect_out("R8 count restarted, 7 edges no error", 1'b0, 1'b1);
        slow_rises(1);
        expect_out("R5 second timeout after 8 edges", 1'b0, 1'b0);
        end_cycle();

        // R7: acknowledge in the same cycle as the synchronized eighth edge
        slow_rises(1);
        start_cycle(20'h93000);
        slow_rises(7);
        @(posedge slow_clk);
        repeat (2) @(posedge clk);
        #1;
        dev_ack_n = 1'b0;
        expect_out("R7 coincident ack acknowledged", 1'b1, 1'b1);
        slow_rises(3);
        expect_out("R7 coincident ack wins over timeout", 1'b1, 1'b1);
        end_cycle();

        expect_out("R9 idle after run", 1'b0, 1'b1);
        step(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule